// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that takes its work from a small on-chip queue rather than a single data register. The queue has sixteen slots. Each slot holds three words: a word to send, a word received, and a command word that picks the word length for that slot. Software fills the queue through an indirect pair of registers: a queue address register and a queue data register. Every access to the data register moves the address on by one, so a run of words needs only one address write.

To start a transfer, software writes a window (first and last slot) and sets the run bit. The engine then works through the window on its own. It sends each slot's word on MOSI and stores the word sampled on MISO into the receive slot with the same index. Chip select stays low for the whole window. At the end, the engine clears the run bit and sets a sticky done flag, which can drive an interrupt.

The control state machine has five states:
- IDLE waits for the run bit.
- LOAD fetches the slot's transmit and command words and starts the shifter.
- SHIFT waits for the shifter to finish the word.
- STORE writes the received word. It then either steps to the next slot (back to LOAD) or, at the last slot of the window, moves to FINISH.
- FINISH clears the run bit, sets the flag and returns to IDLE.

The shifter has two states, SH_IDLE and SH_RUN.

Top module: `qspi_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, irq is 0, and the mode, run, window and interrupt registers all read 0.
- R2: The queue address register (offset 4, 6 bits) picks the array and slot: 0x00-0x0F transmit, 0x10-0x1F receive, 0x20-0x2F command. Each read or accepted write of the queue data register (offset 5) uses the addressed slot and then adds one to the address.
- R3: The window register (offset 2) holds the first slot in bits 3:0 and the last slot in bits 11:8. A run covers the first slot through the last slot inclusive. Each received word goes into the receive slot with the same index. Receive slots outside the window keep their values.
- R4: When command bit 14 is set, the word length comes from mode bits 13:10 (0 means 16, 8-15 as written, 1-7 taken as 8). When bit 14 is clear, the word length is 8. Words are sent MSB first. The received word is right-justified with its upper bits zero.
- R5: Mode bit 9 sets the idle sck level. Mode bit 8 selects the phase: with bit 8 clear, MISO is sampled on the leading edge; with bit 8 set, on the trailing edge. sck equals the bit 9 level whenever no word is shifting.
- R6: Each sck half period lasts mode bits 7:0 bus clocks. A value of 0 freezes sck and the transfer, which then resumes once a nonzero value is written.
- R7: Writing 1 to bit 15 of the run register (offset 1) starts a run, and that bit reads 1 until the window is done, then clears by itself. cs_n is 0 throughout the window, including during every sck edge, and returns to 1 after the last word.
- R8: Interrupt register (offset 3) bit 0 is the done flag, set at the end of each run and cleared by writing 1 to it. Bit 8 is the interrupt enable, and irq equals flag AND enable. If completion and a clear happen in the same cycle, the flag ends up set.
- R9: While the run bit is 1, writes to the window register and to the queue data register are ignored.
- R10: A start write is ignored while mode bit 15 (master enable) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the queue address on the data register) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Done interrupt |

## Verification
Two events can land on the same clock edge: the FINISH state setting the done flag, and a software write-1-to-clear of that flag. The bench provokes this from the ports alone. It watches for cs_n to rise, which marks the FINISH cycle, and in that same cycle issues the clearing write, keeping the enable bit set. It then reads the flag and checks that it is still 1 and that irq is high. A separate write-1-to-clear with no completion pending is then checked to clear the flag.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam logic [2:0] REG_MODE = 3'd0;
    localparam logic [2:0] REG_RUN  = 3'd1;
    localparam logic [2:0] REG_WIN  = 3'd2;
    localparam logic [2:0] REG_IRQ  = 3'd3;
    localparam logic [2:0] REG_QADR = 3'd4;
    localparam logic [2:0] REG_QDAT = 3'd5;

    localparam int CMD_LEN_BIT = 14;

    typedef enum logic [1:0] {
        ARR_TX   = 2'd0,
        ARR_RX   = 2'd1,
        ARR_CMD  = 2'd2,
        ARR_NONE = 2'd3
    } arr_sel_t;

    typedef enum logic [2:0] {
        C_IDLE, C_LOAD, C_SHIFT, C_STORE, C_FINISH
    } ctrl_state_t;

    typedef enum logic {
        SH_IDLE, SH_RUN
    } shift_state_t;
endpackage

// File: rtl/qspi_queue.sv
module qspi_queue
    import qspi_pkg::*;
#(
    parameter int SLOT_N = 16,
    parameter int WORD_W = 16,
    parameter int SLOT_W = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [SLOT_W-1:0] bus_idx,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [SLOT_W-1:0] eng_idx,
    output logic [WORD_W-1:0] eng_tx,
    output logic [WORD_W-1:0] eng_cmd,
    input  logic              rx_we,
    input  logic [WORD_W-1:0] rx_wdata
);
    logic [WORD_W-1:0] tx_vec  [SLOT_N];
    logic [WORD_W-1:0] rx_vec  [SLOT_N];
    logic [WORD_W-1:0] cmd_vec [SLOT_N];

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        logic [WORD_W-1:0] tx_q, rx_q, cmd_q;
        logic              hit;
        assign hit = bus_we && (bus_idx == SLOT_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_q  <= '0;
                rx_q  <= '0;
                cmd_q <= '0;
            end else begin
                if (hit && bus_sel == ARR_TX)  tx_q  <= bus_wdata;
                if (hit && bus_sel == ARR_CMD) cmd_q <= bus_wdata;
                if (rx_we && eng_idx == SLOT_W'(g)) rx_q <= rx_wdata;
                else if (hit && bus_sel == ARR_RX)  rx_q <= bus_wdata;
            end
        end

        assign tx_vec[g]  = tx_q;
        assign rx_vec[g]  = rx_q;
        assign cmd_vec[g] = cmd_q;
    end

    always_comb begin
        unique case (bus_sel)
            ARR_TX:  bus_rdata = tx_vec[bus_idx];
            ARR_RX:  bus_rdata = rx_vec[bus_idx];
            ARR_CMD: bus_rdata = cmd_vec[bus_idx];
            default: bus_rdata = '0;
        endcase
    end

    assign eng_tx  = tx_vec[eng_idx];
    assign eng_cmd = cmd_vec[eng_idx];

    // bus writes are blocked by the top while the engine owns the queue
    assert_no_bus_engine_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_we && bus_we));
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BAUD_W = 8,
    parameter int LEN_W  = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              cpha,
    input  logic [BAUD_W-1:0] baud,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sck_phase,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EDGE_W = LEN_W + 1;

    shift_state_t      state_q;
    logic [BAUD_W-1:0] div_q;
    logic [EDGE_W-1:0] edge_q;
    logic [WORD_W-1:0] sh_q, rx_q, tx_aligned;
    logic [LEN_W-1:0]  len_q;
    logic              sck_q, done_q;
    logic              tick, leading, sample_now, last_edge;

    always_comb begin
        tx_aligned = tx_word << (LEN_W'(WORD_W) - len);
        tick       = (state_q == SH_RUN) && (baud != '0) &&
                     (({1'b0, div_q} + 1'b1) >= {1'b0, baud});
        leading    = ~edge_q[0];
        sample_now = leading ^ cpha;
        last_edge  = (edge_q == EDGE_W'({len_q, 1'b0} - 1'b1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            div_q   <= '0;
            edge_q  <= '0;
            sh_q    <= '0;
            rx_q    <= '0;
            len_q   <= LEN_W'(8);
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                SH_IDLE: begin
                    if (start) begin
                        sh_q    <= tx_aligned;
                        rx_q    <= '0;
                        edge_q  <= '0;
                        div_q   <= '0;
                        sck_q   <= 1'b0;
                        len_q   <= len;
                        state_q <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (tick) begin
                        div_q  <= '0;
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + 1'b1;
                        if (sample_now)
                            rx_q <= {rx_q[WORD_W-2:0], miso};
                        else if (edge_q != '0)
                            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
                        if (last_edge) begin
                            state_q <= SH_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else if (baud != '0) begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign sck_phase = sck_q;
    assign mosi      = sh_q[WORD_W-1];
    assign done      = done_q;
    assign rx_word   = rx_q;

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE) |-> !sck_q);
    assert_frozen_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_RUN && baud == '0) |=> ($stable(sck_q) && $stable(edge_q)));
    assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len >= LEN_W'(8) && len <= LEN_W'(WORD_W)));
endmodule

// File: rtl/qspi_ctrl.sv
module qspi_ctrl
    import qspi_pkg::*;
#(
    parameter int SLOT_N = 16,
    parameter int WORD_W = 16,
    parameter int LEN_W  = $clog2(WORD_W) + 1,
    parameter int SLOT_W = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SLOT_W-1:0] win_start,
    input  logic [SLOT_W-1:0] win_end,
    input  logic [LEN_W-1:0]  prog_len,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              sh_done,
    input  logic [WORD_W-1:0] sh_rx,
    output logic [SLOT_W-1:0] slot,
    output logic              sh_start,
    output logic [LEN_W-1:0]  sh_len,
    output logic [WORD_W-1:0] sh_tx,
    output logic              rx_we,
    output logic [WORD_W-1:0] rx_data,
    output logic              cs_active,
    output logic              finish
);
    ctrl_state_t       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == C_IDLE && go)
                slot_q <= win_start;
            else if (state_q == C_STORE && slot_q != win_end)
                slot_q <= slot_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:   if (go) state_d = C_LOAD;
            C_LOAD:   state_d = C_SHIFT;
            C_SHIFT:  if (sh_done) state_d = C_STORE;
            C_STORE:  state_d = (slot_q == win_end) ? C_FINISH : C_LOAD;
            C_FINISH: state_d = C_IDLE;
            default:  state_d = C_IDLE;
        endcase
    end

    always_comb begin
        sh_start  = 1'b0;
        rx_we     = 1'b0;
        finish    = 1'b0;
        cs_active = 1'b0;
        sh_len    = cmd_word[CMD_LEN_BIT] ? prog_len : LEN_W'(8);
        sh_tx     = tx_word;
        rx_data   = sh_rx;
        unique case (state_q)
            C_IDLE:   ;
            C_LOAD:   begin sh_start = 1'b1; cs_active = 1'b1; end
            C_SHIFT:  cs_active = 1'b1;
            C_STORE:  begin rx_we = 1'b1; cs_active = 1'b1; end
            C_FINISH: finish = 1'b1;
            default:  ;
        endcase
    end

    assign slot = slot_q;

    assert_done_in_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |-> (state_q == C_SHIFT));
    assert_go_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != C_IDLE && state_q != C_FINISH) |-> go);
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int SLOT_N = 16,
    parameter int WORD_W = 16,
    parameter int BAUD_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        irq
);
    localparam int SLOT_W  = $clog2(SLOT_N);
    localparam int QADDR_W = SLOT_W + 2;
    localparam int LEN_W   = $clog2(WORD_W) + 1;

    logic [15:0]        mode_q;
    logic               run_q, flag_q, irq_en_q;
    logic [SLOT_W-1:0]  win_start_q, win_end_q;
    logic [QADDR_W-1:0] qadr_q;

    logic              wr_mode, wr_run, wr_win, wr_irq, wr_qadr, q_we, q_inc;
    logic [3:0]        len_field;
    logic [LEN_W-1:0]  prog_len;
    logic [WORD_W-1:0] q_rdata, eng_tx, eng_cmd, sh_tx, sh_rx, rx_data;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  sh_len;
    logic              sh_start, sh_done, rx_we, cs_active, finish, sck_phase;

    always_comb begin
        wr_mode = bus_wr && bus_addr == REG_MODE;
        wr_run  = bus_wr && bus_addr == REG_RUN;
        wr_win  = bus_wr && bus_addr == REG_WIN && !run_q;
        wr_irq  = bus_wr && bus_addr == REG_IRQ;
        wr_qadr = bus_wr && bus_addr == REG_QADR;
        q_we    = bus_wr && bus_addr == REG_QDAT && !run_q;
        q_inc   = q_we || (!bus_wr && bus_rd && bus_addr == REG_QDAT);
        len_field = mode_q[13:10];
        if (len_field == 4'd0)      prog_len = LEN_W'(16);
        else if (len_field < 4'd8)  prog_len = LEN_W'(8);
        else                        prog_len = LEN_W'(len_field);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            run_q       <= 1'b0;
            flag_q      <= 1'b0;
            irq_en_q    <= 1'b0;
            win_start_q <= '0;
            win_end_q   <= '0;
            qadr_q      <= '0;
        end else begin
            if (wr_mode) mode_q <= bus_wdata;
            if (finish)
                run_q <= 1'b0;
            else if (wr_run && bus_wdata[15] && mode_q[15])
                run_q <= 1'b1;
            if (wr_win) begin
                win_start_q <= bus_wdata[0 +: SLOT_W];
                win_end_q   <= bus_wdata[8 +: SLOT_W];
            end
            if (wr_irq) begin
                irq_en_q <= bus_wdata[8];
                if (bus_wdata[0]) flag_q <= 1'b0;
            end
            if (finish) flag_q <= 1'b1;
            if (wr_qadr)    qadr_q <= bus_wdata[QADDR_W-1:0];
            else if (q_inc) qadr_q <= qadr_q + 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_MODE: bus_rdata = mode_q;
            REG_RUN:  bus_rdata[15] = run_q;
            REG_WIN: begin
                bus_rdata[0 +: SLOT_W] = win_start_q;
                bus_rdata[8 +: SLOT_W] = win_end_q;
            end
            REG_IRQ: begin
                bus_rdata[0] = flag_q;
                bus_rdata[8] = irq_en_q;
            end
            REG_QADR: bus_rdata[QADDR_W-1:0] = qadr_q;
            REG_QDAT: bus_rdata = q_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    qspi_queue #(.SLOT_N(SLOT_N), .WORD_W(WORD_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (q_we),
        .bus_sel   (qadr_q[QADDR_W-1 -: 2]),
        .bus_idx   (qadr_q[SLOT_W-1:0]),
        .bus_wdata (bus_wdata),
        .bus_rdata (q_rdata),
        .eng_idx   (slot),
        .eng_tx    (eng_tx),
        .eng_cmd   (eng_cmd),
        .rx_we     (rx_we),
        .rx_wdata  (rx_data)
    );

    qspi_ctrl #(.SLOT_N(SLOT_N), .WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (run_q),
        .win_start (win_start_q),
        .win_end   (win_end_q),
        .prog_len  (prog_len),
        .tx_word   (eng_tx),
        .cmd_word  (eng_cmd),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .slot      (slot),
        .sh_start  (sh_start),
        .sh_len    (sh_len),
        .sh_tx     (sh_tx),
        .rx_we     (rx_we),
        .rx_data   (rx_data),
        .cs_active (cs_active),
        .finish    (finish)
    );

    qspi_shifter #(.WORD_W(WORD_W), .BAUD_W(BAUD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .len       (sh_len),
        .cpha      (mode_q[8]),
        .baud      (mode_q[BAUD_W-1:0]),
        .tx_word   (sh_tx),
        .miso      (miso),
        .sck_phase (sck_phase),
        .mosi      (mosi),
        .done      (sh_done),
        .rx_word   (sh_rx)
    );

    assign sck  = sck_phase ^ mode_q[9];
    assign cs_n = ~cs_active;
    assign irq  = flag_q & irq_en_q;

    assert_cs_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> run_q);
    assert_run_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !run_q);
    assert_flag_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> flag_q);
    assert_window_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && bus_wr && bus_addr == REG_WIN) |=> ($stable(win_start_q) && $stable(win_end_q)));
    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[15] && !run_q) |=> !run_q);
endmodule

// File: tb/sim_qspi_master.sv
module sim_qspi_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sck, mosi, miso, cs_n, irq;
    logic        inv_q = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] model_rx [16];

    // bench-side slave: loopback, optionally inverted
    assign miso = mosi ^ inv_q;

    qspi_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    // serial monitor, evaluated away from the active edge
    logic cpol_cur = 1'b0, cpha_cur = 1'b0, mon_clr = 1'b0;
    logic prev_sck = 1'b0, edge_seen = 1'b0;
    int   bits_seen = 0, gap = 0, min_gap = 1000, cs_bad = 0;
    logic mon_bits [256];

    always @(negedge clk) begin
        if (mon_clr) begin
            bits_seen = 0; gap = 0; min_gap = 1000; cs_bad = 0; edge_seen = 1'b0;
            prev_sck = sck;
        end else begin
            gap = gap + 1;
            if (sck !== prev_sck) begin
                logic lead;
                lead = (sck != cpol_cur);
                if (cs_n) cs_bad = cs_bad + 1;
                if (edge_seen && gap < min_gap) min_gap = gap;
                gap = 0;
                edge_seen = 1'b1;
                if (lead != cpha_cur) begin
                    if (bits_seen < 256) mon_bits[bits_seen] = mosi;
                    bits_seen = bits_seen + 1;
                end
                prev_sck = sck;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic mon_clear();
        @(negedge clk); #1 mon_clr = 1'b1;
        @(negedge clk); #1 mon_clr = 1'b0;
    endtask

    function automatic logic [15:0] len_mask(input int l);
        return (l >= 16) ? 16'hFFFF : 16'((32'h1 << l) - 1);
    endfunction

    function automatic int eff_len(input bit use_prog, input int lenf);
        if (!use_prog) return 8;
        if (lenf == 0) return 16;
        if (lenf < 8) return 8;
        return lenf;
    endfunction

    task automatic wait_window(input bit clash, input string req);
        int t = 0;
        while (cs_n == 1'b1 && t < 100) begin @(negedge clk); t++; end
        while (cs_n == 1'b0 && t < 60000) begin @(negedge clk); t++; end
        chk(t < 60000, req, "window finished in time", t, 0);
        if (clash) begin
            // cs_n just rose: the completion edge is next, clear lands on it
            bus_addr = 3'd3; bus_wdata = 16'h0101; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_window(input int s, input int e, input bit cpol, input bit cpha,
                              input int baud, input int lenf, input bit inv,
                              input bit poke, input bit clash);
        logic [15:0] tx [16];
        bit          prog [16];
        logic        exp_bits [256];
        logic [15:0] rd, win_word;
        int          total = 0, mism = 0;
        cpol_cur = cpol; cpha_cur = cpha; inv_q = inv;
        for (int i = s; i <= e; i++) begin
            tx[i]   = 16'($urandom);
            prog[i] = 1'($urandom);
            for (int b = eff_len(prog[i], lenf) - 1; b >= 0; b--) begin
                exp_bits[total] = tx[i][b];
                total++;
            end
            model_rx[i] = (tx[i] ^ {16{inv}}) & len_mask(eff_len(prog[i], lenf));
        end
        bus_write(3'd0, {1'b1, 1'b0, 4'(lenf), cpol, cpha, 8'(baud)});
        bus_write(3'd4, 16'(s));
        for (int i = s; i <= e; i++) bus_write(3'd5, tx[i]);
        bus_write(3'd4, 16'(32 + s));
        for (int i = s; i <= e; i++) bus_write(3'd5, prog[i] ? 16'h4000 : 16'h0000);
        win_word = {4'd0, 4'(e), 4'd0, 4'(s)};
        bus_write(3'd2, win_word);
        bus_write(3'd3, 16'h0101);
        mon_clear();
        bus_write(3'd1, 16'h8000);
        if (poke) begin
            bus_write(3'd2, 16'h0F0F);
            bus_write(3'd4, 16'(s));
            bus_write(3'd5, ~tx[s]);
        end
        wait_window(clash, clash ? "R8" : "R7");
        bus_read(3'd1, rd);
        chk(rd == 16'h0000, "R7", "run bit cleared", rd, 0);
        bus_read(3'd3, rd);
        chk(rd[0] == 1'b1, "R8", clash ? "flag kept over same-cycle clear" : "done flag set", rd, 16'h0101);
        chk(irq == 1'b1, "R8", "irq with enable", irq, 1);
        chk(cs_n == 1'b1, "R7", "cs released", cs_n, 1);
        chk(sck == cpol, "R5", "sck idle level", sck, cpol);
        chk(cs_bad == 0, "R7", "sck edges outside cs", cs_bad, 0);
        chk(bits_seen == total, "R4", "bit count", bits_seen, total);
        for (int k = 0; k < total && k < 256; k++)
            if (mon_bits[k] !== exp_bits[k]) mism++;
        chk(mism == 0, "R4", "MSB-first stream mismatches", mism, 0);
        chk(min_gap == baud, "R6", "sck half period", min_gap, baud);
        bus_write(3'd4, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            bus_read(3'd5, rd);
            chk(rd == model_rx[i], "R3", $sformatf("rx slot %0d", i), rd, model_rx[i]);
        end
        if (poke) begin
            bus_read(3'd2, rd);
            chk(rd == win_word, "R9", "window write ignored while running", rd, win_word);
            bus_write(3'd4, 16'(s));
            bus_read(3'd5, rd);
            chk(rd == tx[s], "R9", "queue write ignored while running", rd, tx[s]);
        end
    endtask

    initial begin
        logic [15:0] rd;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 16; i++) model_rx[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
        chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        bus_read(3'd0, rd); chk(rd == 0, "R1", "mode reg", rd, 0);
        bus_read(3'd1, rd); chk(rd == 0, "R1", "run reg", rd, 0);
        bus_read(3'd2, rd); chk(rd == 0, "R1", "window reg", rd, 0);
        bus_read(3'd3, rd); chk(rd == 0, "R1", "irq reg", rd, 0);

        // R2 indirect access and auto-increment
        bus_write(3'd4, 16'h0003);
        bus_write(3'd5, 16'h1111);
        bus_write(3'd5, 16'h2222);
        bus_read(3'd4, rd); chk(rd == 16'h0005, "R2", "address after two writes", rd, 5);
        bus_write(3'd4, 16'h0003);
        bus_read(3'd5, rd); chk(rd == 16'h1111, "R2", "tx slot 3", rd, 16'h1111);
        bus_read(3'd5, rd); chk(rd == 16'h2222, "R2", "tx slot 4 by increment", rd, 16'h2222);
        bus_write(3'd4, 16'h0013);
        bus_read(3'd5, rd); chk(rd == 16'h0000, "R2", "rx slot 3 array select", rd, 0);
        bus_write(3'd4, 16'h002F);
        bus_write(3'd5, 16'h4000);
        bus_read(3'd4, rd); chk(rd == 16'h0030, "R2", "address past command array", rd, 16'h30);

        // R10 start ignored with master enable clear
        cpol_cur = 1'b0;
        bus_write(3'd0, 16'h0002);
        bus_write(3'd1, 16'h8000);
        repeat (10) @(negedge clk);
        bus_read(3'd1, rd); chk(rd == 16'h0000, "R10", "run bit stays clear", rd, 0);
        chk(cs_n == 1'b1, "R10", "cs stays released", cs_n, 1);

        // directed windows: full queue, single slot 16-bit, ignore-while-running
        run_window(0, 15, 1'b0, 1'b0, 2, 12, 1'b0, 1'b0, 1'b0);
        run_window(5, 5, 1'b1, 1'b1, 3, 0, 1'b1, 1'b0, 1'b0);
        run_window(0, 7, 1'b0, 1'b1, 4, 9, 1'b0, 1'b1, 1'b0);

        // R8 completion and clear in the same cycle, then a plain clear
        run_window(2, 4, 1'b1, 1'b0, 2, 15, 1'b0, 1'b0, 1'b1);
        bus_write(3'd3, 16'h0001);
        bus_read(3'd3, rd); chk(rd == 16'h0000, "R8", "write-one clears flag", rd, 0);
        chk(irq == 1'b0, "R8", "irq low after clear", irq, 0);

        // R6 zero divider freezes, then resumes
        cpol_cur = 1'b1; cpha_cur = 1'b0; inv_q = 1'b0;
        bus_write(3'd0, 16'hA200);
        bus_write(3'd4, 16'h0002); bus_write(3'd5, 16'h00A5);
        bus_write(3'd4, 16'h0022); bus_write(3'd5, 16'h4000);
        bus_write(3'd2, 16'h0202);
        mon_clear();
        bus_write(3'd1, 16'h8000);
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b0, "R7", "cs held during frozen word", cs_n, 0);
        chk(sck == 1'b1, "R6", "sck frozen at idle", sck, 1);
        chk(bits_seen == 0, "R6", "no bits while frozen", bits_seen, 0);
        bus_read(3'd1, rd); chk(rd == 16'h8000, "R6", "run still set while frozen", rd, 16'h8000);
        bus_write(3'd0, 16'hA202);
        wait_window(1'b0, "R6");
        model_rx[2] = 16'h00A5;
        bus_write(3'd4, 16'h0012);
        bus_read(3'd5, rd); chk(rd == 16'h00A5, "R6", "word after resume", rd, 16'h00A5);

        // constrained random windows
        for (int n = 0; n < 6; n++) begin
            int s, e, l;
            s = $urandom_range(0, 15);
            e = $urandom_range(s, 15);
            l = $urandom_range(7, 15);
            run_window(s, e, 1'($urandom), 1'($urandom), $urandom_range(2, 4),
                       (l == 7) ? 0 : l, 1'($urandom), 1'b0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule